// File: doc/BRIEF.md
# NAND Flash Register Bridge

This block lets a bus master drive a raw 8-bit NAND flash device one cycle at a time. The host sees a small bank of word registers behind a byte-addressed request/acknowledge port. Each write to the command, address or data register starts one write strobe on the flash pins. The latch lines and the I/O byte follow the register that was written. A read of the data register starts one read strobe and returns the byte sampled from the flash I/O bus. A read of the status register returns the ready/busy pin.

A configuration register gates the whole bridge. While its enable bit is clear, the flash pins stay idle with the chip deselected and write protect active. Writes to every other register are then dropped. The same register also holds the chip-enable level and two 3-bit counts. These set the strobe low time and the hold time, in bus clock cycles. The host must wait for the acknowledge pulse after each request. The busy output marks the cycles in which a strobe sequence is running.

Top module: `nand_reg_bridge`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero and the bridge is disabled. The outputs are then ack=0, busy=0, cle=0, ale=0, ce_n=1, wp_n=0, we_n=1, re_n=1 and io_oe=0.
- R2: The register index is taken from addr[4:2], so addr[5] and addr[1:0] are ignored. Index 0 is configuration, 1 is command, 2 is address, 3 is data and 4 is status. Indexes 5 to 7 read zero and ignore writes.
- R3: While configuration bit 15 is clear, a write to any register other than configuration is acknowledged with no effect: no strobe occurs and the stored value does not change. A data-register read in this state returns the stored byte without a strobe.
- R4: While bit 15 is set, ce_n equals configuration bit 11 and wp_n is 1. While bit 15 is clear, ce_n is 1 and wp_n is 0.
- R5: A command write stores wdata. During its strobe it drives cle=1, ale=0, io_oe=1 and io_out=wdata[7:0].
- R6: An address write stores wdata. During its strobe it drives ale=1, cle=0, io_oe=1 and io_out=wdata[7:0]. cle and ale are never high together.
- R7: A data write drives cle=0, ale=0, io_oe=1 and io_out=wdata[7:0] during its strobe.
- R8: A data read pulses re_n with io_oe=0 and cle=ale=0. The byte on io_in in the last low cycle of re_n is returned in rdata[7:0], with the upper bits zero. we_n and re_n are never low together.
- R9: A status read returns flash_rdy in rdata[0] and zero in all other bits.
- R10: The strobe stays low for cfg[2:0]+1 cycles. A hold of cfg[6:4]+1 cycles follows, with the latch lines and the I/O byte unchanged. ack goes high (cfg[2:0]+cfg[6:4]+2) cycles after the edge that accepts the request. busy is high from that edge until ack rises.
- R11: Configuration, command and address reads return the last value written. They, and every access with no strobe, are acknowledged at the edge that accepts them.
- R12: A request made while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, sampled when busy is low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 6 | Byte address inside the 64-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with ack |
| ack | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Strobe sequence in progress |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| wp_n | output | 1 | Write protect, active low |
| io_out | output | 8 | Flash I/O byte driven out |
| io_in | input | 8 | Flash I/O byte sampled in |
| io_oe | output | 1 | Output enable for io_out |
| flash_rdy | input | 1 | Flash ready/busy pin |

## Verification
The assertions assume that the host issues a request only as a single-cycle pulse. They also assume that configuration is never rewritten while a strobe is running. The stimulus honours both assumptions: every access drops req after one cycle and waits for ack. The one deliberate exception is the busy-overlap test, and the design must ignore that request. io_in and flash_rdy are held steady around each read strobe, so the captured byte is well defined.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
    localparam int IDX_W   = 3;
    localparam logic [IDX_W-1:0] IDX_CFG  = 3'd0;
    localparam logic [IDX_W-1:0] IDX_CMD  = 3'd1;
    localparam logic [IDX_W-1:0] IDX_ADR  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_DAT  = 3'd3;
    localparam logic [IDX_W-1:0] IDX_STAT = 3'd4;
    localparam int NUM_IDX = 1 << IDX_W;

    localparam int CFG_EN_BIT   = 15;
    localparam int CFG_CE_BIT   = 11;
    localparam int CFG_PW_LSB   = 0;
    localparam int CFG_HOLD_LSB = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_STROBE,
        SEQ_HOLD
    } seq_state_e;
endpackage

// File: rtl/nrb_decode.sv
module nrb_decode
    import nrb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_IDX-1:0] sel
);
    assign idx = addr[IDX_W+1:2];

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_sel
        assign sel[g] = (idx == IDX_W'(g));
    end

    always_comb begin
        assert ($onehot0(sel)) else $error("AST_SEL_ONEHOT"); // R2
    end
endmodule

// File: rtl/nrb_strobe_seq.sv
module nrb_strobe_seq
    import nrb_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             is_read,
    input  logic [CNT_W-1:0] pw,
    input  logic [CNT_W-1:0] hold,
    output logic             strobe_low,
    output logic             in_hold,
    output logic             capture,
    output logic             done
);
    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             rd;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            SEQ_IDLE: begin
                if (start) begin
                    d.st  = SEQ_STROBE;
                    d.cnt = pw;
                    d.rd  = is_read;
                end
            end
            SEQ_STROBE: begin
                if (q.cnt == '0) begin
                    d.st  = SEQ_HOLD;
                    d.cnt = hold;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (q.cnt == '0) begin
                    d.st = SEQ_IDLE;
                    d.rd = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '{st: SEQ_IDLE, cnt: '0, rd: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign strobe_low = (q.st == SEQ_STROBE);
    assign in_hold    = (q.st == SEQ_HOLD);
    assign capture    = strobe_low && (q.cnt == '0) && q.rd;
    assign done       = in_hold && (q.cnt == '0);

    // Watch the low run of the strobe against the programmed width.
    logic [CNT_W:0] low_run_q;
    logic [CNT_W:0] pw_lim_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            low_run_q <= '0;
            pw_lim_q  <= '0;
        end else begin
            if (start && q.st == SEQ_IDLE) pw_lim_q <= {1'b0, pw} + 1'b1;
            low_run_q <= strobe_low ? low_run_q + 1'b1 : '0;
        end
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        low_run_q <= pw_lim_q) else $error("AST_STROBE_WIDTH"); // R10
    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> q.st == SEQ_IDLE) else $error("AST_START_IDLE"); // R12
    AST_HOLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $rose(in_hold) |-> $past(strobe_low)) else $error("AST_HOLD_FOLLOWS"); // R10
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
    import nrb_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int IO_W   = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ack,
    output logic              busy,
    output logic              cle,
    output logic              ale,
    output logic              ce_n,
    output logic              we_n,
    output logic              re_n,
    output logic              wp_n,
    output logic [IO_W-1:0]   io_out,
    input  logic [IO_W-1:0]   io_in,
    output logic              io_oe,
    input  logic              flash_rdy
);
    localparam int IO_PAD = DATA_W - IO_W;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] adr;
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] rdata;
        logic              ack;
        logic              busy;
        logic              cle;
        logic              ale;
        logic              oe;
        logic              rd_op;
        logic [IO_W-1:0]   io_out;
    } br_t;

    br_t q, d;

    logic [IDX_W-1:0]   idx;
    logic [NUM_IDX-1:0] sel;
    logic               start;
    logic               start_rd;
    logic               strobe_low;
    logic               in_hold;
    logic               capture;
    logic               done;
    logic               enabled;
    logic               accept;

    nrb_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (addr),
        .idx  (idx),
        .sel  (sel)
    );

    nrb_strobe_seq #(.CNT_W(CNT_W)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .is_read    (start_rd),
        .pw         (q.cfg[CFG_PW_LSB +: CNT_W]),
        .hold       (q.cfg[CFG_HOLD_LSB +: CNT_W]),
        .strobe_low (strobe_low),
        .in_hold    (in_hold),
        .capture    (capture),
        .done       (done)
    );

    assign enabled = q.cfg[CFG_EN_BIT];
    assign accept  = req && !q.busy;

    always_comb begin
        d        = q;
        d.ack    = 1'b0;
        start    = 1'b0;
        start_rd = 1'b0;

        if (accept) begin
            if (we) begin
                if (sel[IDX_CFG]) begin
                    d.cfg = wdata;
                    d.ack = 1'b1;
                end else if (!enabled) begin
                    d.ack = 1'b1;
                end else if (sel[IDX_CMD] || sel[IDX_ADR] || sel[IDX_DAT]) begin
                    if (sel[IDX_CMD]) d.cmd = wdata;
                    if (sel[IDX_ADR]) d.adr = wdata;
                    if (sel[IDX_DAT]) d.dat = wdata;
                    d.cle    = sel[IDX_CMD];
                    d.ale    = sel[IDX_ADR];
                    d.oe     = 1'b1;
                    d.io_out = wdata[IO_W-1:0];
                    d.busy   = 1'b1;
                    start    = 1'b1;
                end else begin
                    d.ack = 1'b1;
                end
            end else begin
                unique case (idx)
                    IDX_CFG:  begin d.rdata = q.cfg; d.ack = 1'b1; end
                    IDX_CMD:  begin d.rdata = q.cmd; d.ack = 1'b1; end
                    IDX_ADR:  begin d.rdata = q.adr; d.ack = 1'b1; end
                    IDX_DAT: begin
                        if (enabled) begin
                            d.busy   = 1'b1;
                            d.rd_op  = 1'b1;
                            d.cle    = 1'b0;
                            d.ale    = 1'b0;
                            d.oe     = 1'b0;
                            start    = 1'b1;
                            start_rd = 1'b1;
                        end else begin
                            d.rdata = q.dat;
                            d.ack   = 1'b1;
                        end
                    end
                    IDX_STAT: begin
                        d.rdata = DATA_W'(flash_rdy);
                        d.ack   = 1'b1;
                    end
                    default: begin
                        d.rdata = '0;
                        d.ack   = 1'b1;
                    end
                endcase
            end
        end

        if (capture) begin
            d.dat   = {{IO_PAD{1'b0}}, io_in};
            d.rdata = {{IO_PAD{1'b0}}, io_in};
        end

        if (done) begin
            d.busy  = 1'b0;
            d.ack   = 1'b1;
            d.cle   = 1'b0;
            d.ale   = 1'b0;
            d.oe    = 1'b0;
            d.rd_op = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata  = q.rdata;
    assign ack    = q.ack;
    assign busy   = q.busy;
    assign cle    = q.cle;
    assign ale    = q.ale;
    assign io_out = q.io_out;
    assign io_oe  = q.oe;
    assign we_n   = !(strobe_low && !q.rd_op);
    assign re_n   = !(strobe_low && q.rd_op);
    assign ce_n   = enabled ? q.cfg[CFG_CE_BIT] : 1'b1;
    assign wp_n   = enabled;

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale)) else $error("AST_LATCH_EXCL"); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        we_n || re_n) else $error("AST_STROBE_EXCL"); // R8
    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        io_oe |-> (busy && re_n)) else $error("AST_OE_WRITE_ONLY"); // R5
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
        !enabled |-> (ce_n && !wp_n && we_n && re_n)) else $error("AST_DISABLED_IDLE"); // R4
    AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> busy) else $error("AST_STROBE_BUSY"); // R10
    AST_ACK_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ack) else $error("AST_ACK_ENDS_BUSY"); // R10
    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(q.cfg)) else $error("AST_CFG_FROZEN_BUSY"); // R12
endmodule

// File: tb/test_nand_reg_bridge.sv
`timescale 1ns/1ps
module test_nand_reg_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic        req, we;
    logic [5:0]  addr;
    logic [31:0] wdata, rdata;
    logic        ack, busy, cle, ale, ce_n, we_n, re_n, wp_n, io_oe, flash_rdy;
    logic [7:0]  io_out, io_in;

    int nchk = 0, nerr = 0, wlow = 0, rlow = 0, lat = 0;
    logic s_cle, s_ale, s_oe, r_cle, r_ale, r_oe;
    logic [7:0] s_io;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nand_reg_bridge i_nand_reg_bridge (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack(ack), .busy(busy), .cle(cle), .ale(ale), .ce_n(ce_n),
        .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .io_out(io_out), .io_in(io_in),
        .io_oe(io_oe), .flash_rdy(flash_rdy)
    );

    always @(negedge clk) begin
        if (!we_n) begin
            wlow++; s_cle = cle; s_ale = ale; s_oe = io_oe; s_io = io_out;
        end
        if (!re_n) begin
            rlow++; r_cle = cle; r_ale = ale; r_oe = io_oe;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [5:0] a, input logic [31:0] wd);
        wlow = 0; rlow = 0;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = wd;
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        while (!ack && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // {we, addr, wdata, expected rdata}
    localparam int NV = 9;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 6'h00, 32'h0000_8021, 32'h0},
        {1'b0, 6'h00, 32'h0,         32'h0000_8021},
        {1'b1, 6'h04, 32'h0000_00A5, 32'h0},
        {1'b0, 6'h24, 32'h0,         32'h0000_00A5},
        {1'b1, 6'h0B, 32'h1234_563C, 32'h0},
        {1'b0, 6'h08, 32'h0,         32'h1234_563C},
        {1'b0, 6'h14, 32'h0,         32'h0},
        {1'b1, 6'h18, 32'h0000_FFFF, 32'h0},
        {1'b0, 6'h38, 32'h0,         32'h0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        io_in = 8'h00; flash_rdy = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ack", ack, 0);   chk("R1 busy", busy, 0);
        chk("R1 cle", cle, 0);   chk("R1 ale", ale, 0);
        chk("R1 ce_n", ce_n, 1); chk("R1 wp_n", wp_n, 0);
        chk("R1 we_n", we_n, 1); chk("R1 re_n", re_n, 1);
        chk("R1 io_oe", io_oe, 0);
        access(1'b0, 6'h00, 0);
        chk("R1 cfg zero", rdata, 0);

        // R2 R11 vector table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][70], VEC[i][69:64], VEC[i][63:32]);
            if (!VEC[i][70]) chk($sformatf("R2 R11 vec%0d", i), rdata, VEC[i][31:0]);
        end

        // R4 chip enable level
        chk("R4 ce_n low", ce_n, 0); chk("R4 wp_n high", wp_n, 1);
        access(1'b1, 6'h00, 32'h0000_8821);
        chk("R4 ce_n high", ce_n, 1);
        access(1'b1, 6'h00, 32'h0000_8021);

        // R5 R10 command write, pw=1 hold=2
        access(1'b1, 6'h04, 32'h0000_00C3);
        chk("R10 wlow", wlow, 2); chk("R10 latency", lat, 5);
        chk("R5 cle", s_cle, 1); chk("R5 ale", s_ale, 0);
        chk("R5 oe", s_oe, 1);   chk("R5 io", s_io, 8'hC3);
        chk("R10 busy low after", busy, 0);
        chk("R10 oe low after", io_oe, 0);

        // R6 address write
        access(1'b1, 6'h08, 32'h0000_0017);
        chk("R6 ale", s_ale, 1); chk("R6 cle", s_cle, 0);
        chk("R6 io", s_io, 8'h17); chk("R6 wlow", wlow, 2);

        // R7 data write
        access(1'b1, 6'h0C, 32'h0000_0099);
        chk("R7 cle", s_cle, 0); chk("R7 ale", s_ale, 0);
        chk("R7 oe", s_oe, 1);   chk("R7 io", s_io, 8'h99);

        // R8 data read
        io_in = 8'h5A;
        access(1'b0, 6'h0C, 0);
        chk("R8 rdata", rdata, 32'h5A); chk("R8 rlow", rlow, 2);
        chk("R8 wlow", wlow, 0);        chk("R8 oe", r_oe, 0);
        chk("R8 cle", r_cle, 0);        chk("R8 ale", r_ale, 0);
        chk("R8 latency", lat, 5);

        // R9 status
        flash_rdy = 1'b1;
        access(1'b0, 6'h10, 0); chk("R9 ready", rdata, 1);
        flash_rdy = 1'b0;
        access(1'b0, 6'h10, 0); chk("R9 busy", rdata, 0);

        // R10 other timings
        access(1'b1, 6'h00, 32'h0000_8003);
        access(1'b1, 6'h04, 32'h0000_0001);
        chk("R10 pw3 wlow", wlow, 4); chk("R10 pw3 latency", lat, 5);
        access(1'b1, 6'h00, 32'h0000_8000);
        access(1'b1, 6'h04, 32'h0000_0002);
        chk("R10 pw0 wlow", wlow, 1); chk("R10 pw0 latency", lat, 2);
        access(1'b0, 6'h04, 0); chk("R11 cmd readback", rdata, 2);
        chk("R11 simple latency", lat, 0);

        // R3 disabled gating
        access(1'b1, 6'h00, 32'h0000_0021);
        chk("R4 disabled ce_n", ce_n, 1); chk("R4 disabled wp_n", wp_n, 0);
        access(1'b1, 6'h04, 32'h0000_0077);
        chk("R3 no strobe", wlow, 0); chk("R3 ack now", lat, 0);
        io_in = 8'hEE;
        access(1'b0, 6'h0C, 0);
        chk("R3 no read strobe", rlow, 0); chk("R3 data kept", rdata, 32'h5A);
        access(1'b1, 6'h00, 32'h0000_8021);
        access(1'b0, 6'h04, 0);
        chk("R3 cmd unchanged", rdata, 2);

        // R12 request while busy
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 6'h04; wdata = 32'h11;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk("R12 busy seen", busy, 1);
        req = 1'b1; we = 1'b1; addr = 6'h00; wdata = 32'h0;
        @(negedge clk);
        req = 1'b0;
        while (!ack) @(negedge clk);
        access(1'b0, 6'h00, 0); chk("R12 cfg kept", rdata, 32'h8021);
        access(1'b0, 6'h04, 0); chk("R12 cmd stored", rdata, 32'h11);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule